// File: doc/BRIEF.md
# Decrementer Timer with Exception Request

The block holds a 32-bit down-counter that steps once per timer tick and raises an exception request whenever its most significant bit goes from 0 to 1. In steady counting, that happens when the count wraps from zero to all ones. A software write that sets the top bit from a cleared state raises the same request.

The tick comes from one of two sources, chosen by a select input. With the select low, a prescaler divides the processor clock by 16. With the select high, an external tick line is synchronised through two flops and edge-detected. Counting only runs while the enable input is high. Requests that arrive before the exception is taken merge into one pending request, and the acknowledge input clears it. A mask input blocks new requests from being latched.

Only power-on reset clears and stops the counter. The hard/soft reset input leaves the count and its progress alone and clears only the pending request. The request logic is a two-state machine:
- ST_IDLE goes to ST_PEND on RAISE, which is an unmasked top-bit rise.
- ST_PEND goes to ST_IDLE on TAKE, which is an acknowledge with no new rise.
- ST_PEND stays in ST_PEND on REARM, which is an acknowledge together with an unmasked rise.
- ST_PEND also stays in ST_PEND on HOLD, which covers every other case.
- The soft reset forces ST_IDLE.

Top module: `dec_timer`

## Requirements
- R1: While por_n is low, the count is cleared to 0 at once (asynchronously) and req_o is low.
- R2: While run_en is low and no write is made, rd_data holds its value.
- R3: With src_sel=0, the count decreases by one every 16 clocks. The first step lands on the 16th rising edge after run_en is first sampled high. The prescaler restarts whenever run_en is low or src_sel is 1.
- R4: With src_sel=1 and run_en high, each rising edge of ext_tick decrements the count once, on the 3rd clock edge after the edge. A level held high gives no further steps.
- R5: A count stepping from 0x00000000 to 0xFFFFFFFF raises req_o on the same edge. This includes the first wrap after power-on, before any write.
- R6: A write with wr_en=1 loads wr_data on the next edge. req_o rises on that edge exactly when bit 31 was 0 before the write and is 1 after it.
- R7: When a write and a tick fall in the same cycle, the written value is loaded and that tick is lost.
- R8: Further top-bit rises while a request is pending leave a single request. One ack_i cycle drops req_o on the next edge.
- R9: A rise while mask_i is high is not latched. A request already pending stays high while mask_i is high.
- R10: While sys_rst_n is low, req_o is cleared. The count value and its stepping are unaffected.
- R11: An ack_i in the same cycle as an unmasked top-bit rise leaves req_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | Hard/soft reset, active low; clears only the pending request |
| run_en | input | 1 | Counting enable |
| src_sel | input | 1 | Tick source: 0 = clock divided by 16, 1 = external tick |
| ext_tick | input | 1 | External tick line (asynchronous) |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| rd_data | output | 32 | Current count |
| req_o | output | 1 | Pending exception request |
| ack_i | input | 1 | Exception taken |
| mask_i | input | 1 | Blocks new requests from being latched |

## Verification
The bench targets the exact edge of the first prescaled step and the first wrap after power-on. A design with an off-by-one prescaler shows a stale or early count at those edges, and one that needs an initial write never raises the request. It checks the write/tick collision, where a design that merges both loads the value minus one. It also checks writes that keep or clear the top bit, where a level-based detector would raise a spurious request. Finally, it checks merged and masked rises, an acknowledge that coincides with a new rise, and the soft reset. A design that counts requests, latches masked rises, drops the coinciding rise, or clears the count on soft reset gives the wrong req_o or rd_data.

// File: rtl/dec_pkg.sv
package dec_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } req_state_e;

    typedef enum logic {
        SRC_PRESCALE = 1'b0,
        SRC_EXT      = 1'b1
    } tick_src_e;
endpackage

// File: rtl/dec_tick_gen.sv
module dec_tick_gen #(
    parameter int unsigned PRESCALE    = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic run_en,
    input  logic src_sel,
    input  logic ext_tick,
    output logic tick_o
);
    import dec_pkg::*;

    localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic [SYNC_STAGES:0] sync_q;
    logic                 ext_rise;
    logic                 pre_tick;

    // synchroniser plus one extra stage for edge detection
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-1:0], ext_tick};
        end
    end

    assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

    generate
        if (PRESCALE <= 1) begin : g_nodiv
            assign pre_tick = run_en && (tick_src_e'(src_sel) == SRC_PRESCALE);
        end else begin : g_div
            localparam logic [PW-1:0] P_LAST = PW'(PRESCALE - 1);
            logic [PW-1:0] pcnt;

            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) begin
                    pcnt <= '0;
                end else if (!run_en || (tick_src_e'(src_sel) == SRC_EXT)) begin
                    pcnt <= '0;
                end else if (pcnt == P_LAST) begin
                    pcnt <= '0;
                end else begin
                    pcnt <= pcnt + 1'b1;
                end
            end

            assign pre_tick = run_en && (tick_src_e'(src_sel) == SRC_PRESCALE)
                              && (pcnt == P_LAST);
        end
    endgenerate

    always_comb begin
        unique case (tick_src_e'(src_sel))
            SRC_PRESCALE: tick_o = pre_tick;
            SRC_EXT:      tick_o = run_en && ext_rise;
        endcase
    end
endmodule

// File: rtl/dec_count.sv
module dec_count #(
    parameter int unsigned DEC_W = 32
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [DEC_W-1:0] wr_data,
    output logic [DEC_W-1:0] cnt_o,
    output logic             msb_rise_o
);
    logic [DEC_W-1:0] cnt_q;
    logic [DEC_W-1:0] cnt_nxt;

    // a write takes priority; a tick in the same cycle is dropped
    always_comb begin
        if (wr_en) begin
            cnt_nxt = wr_data;
        end else if (tick) begin
            cnt_nxt = cnt_q - 1'b1;
        end else begin
            cnt_nxt = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
        end
    end

    assign msb_rise_o = ~cnt_q[DEC_W-1] & cnt_nxt[DEC_W-1];
    assign cnt_o      = cnt_q;
endmodule

// File: rtl/dec_req_fsm.sv
module dec_req_fsm (
    input  logic clk,
    input  logic por_n,
    input  logic sys_rst_n,
    input  logic rise_i,
    input  logic mask_i,
    input  logic ack_i,
    output logic req_o
);
    import dec_pkg::*;

    req_state_e st_q;
    req_state_e st_nxt;
    logic       new_req;

    assign new_req = rise_i && !mask_i;

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: if (new_req) st_nxt = ST_PEND;                  // RAISE
            ST_PEND: if (ack_i && !new_req) st_nxt = ST_IDLE;        // TAKE; else REARM/HOLD
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= ST_IDLE;
        end else if (!sys_rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    always_comb begin
        req_o = (st_q == ST_PEND);
    end
endmodule

// File: rtl/dec_timer.sv
module dec_timer #(
    parameter int unsigned DEC_W       = 32,
    parameter int unsigned PRESCALE    = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             sys_rst_n,
    input  logic             run_en,
    input  logic             src_sel,
    input  logic             ext_tick,
    input  logic             wr_en,
    input  logic [DEC_W-1:0] wr_data,
    output logic [DEC_W-1:0] rd_data,
    output logic             req_o,
    input  logic             ack_i,
    input  logic             mask_i
);
    logic tick;
    logic msb_rise;

    dec_tick_gen #(
        .PRESCALE    (PRESCALE),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_tick (
        .clk      (clk),
        .por_n    (por_n),
        .run_en   (run_en),
        .src_sel  (src_sel),
        .ext_tick (ext_tick),
        .tick_o   (tick)
    );

    dec_count #(
        .DEC_W (DEC_W)
    ) u_cnt (
        .clk        (clk),
        .por_n      (por_n),
        .tick       (tick),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .cnt_o      (rd_data),
        .msb_rise_o (msb_rise)
    );

    dec_req_fsm u_req (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .rise_i    (msb_rise),
        .mask_i    (mask_i),
        .ack_i     (ack_i),
        .req_o     (req_o)
    );
endmodule

// File: rtl/dec_timer_chk.sv
module dec_timer_chk #(
    parameter int unsigned DEC_W = 32
) (
    input logic             clk,
    input logic             por_n,
    input logic             sys_rst_n,
    input logic             run_en,
    input logic             wr_en,
    input logic [DEC_W-1:0] rd_data,
    input logic             req_o,
    input logic             ack_i,
    input logic             mask_i
);
    AST_POR_CLEARS: assert property (@(posedge clk) !por_n |-> (rd_data == '0 && !req_o)); // R1

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!por_n)
        (!run_en && !wr_en) |=> $stable(rd_data)); // R2

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!por_n)
        !wr_en |=> (rd_data == $past(rd_data) || rd_data == $past(rd_data) - 1'b1)); // R3

    AST_RISE_RAISES: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        ($rose(rd_data[DEC_W-1]) && !$past(mask_i) && $past(sys_rst_n)) |-> req_o); // R5

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        !req_o |=> (!req_o || $rose(rd_data[DEC_W-1]))); // R9

    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (req_o && !ack_i) |=> req_o); // R8

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (req_o && ack_i) |=> (!req_o || $rose(rd_data[DEC_W-1]))); // R11

    AST_SOFT_RST_DROP: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst_n |=> !req_o); // R10
endmodule

bind dec_timer dec_timer_chk #(.DEC_W(DEC_W)) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .sys_rst_n (sys_rst_n),
    .run_en    (run_en),
    .wr_en     (wr_en),
    .rd_data   (rd_data),
    .req_o     (req_o),
    .ack_i     (ack_i),
    .mask_i    (mask_i)
);

// File: tb/tb_dec_timer.sv
`timescale 1ns/1ps
module tb_dec_timer;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b1;
    logic        run_en = 1'b0;
    logic        src_sel = 1'b0;
    logic        ext_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        req_o;
    logic        ack_i = 1'b0;
    logic        mask_i = 1'b0;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    dec_timer dut (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .run_en(run_en),
        .src_sel(src_sel), .ext_tick(ext_tick), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .req_o(req_o), .ack_i(ack_i), .mask_i(mask_i)
    );

    // {first value, second value, mask, expected request}
    localparam logic [65:0] VECS [0:7] = '{
        {32'h00000000, 32'h80000000, 1'b0, 1'b1},
        {32'h7FFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b1},
        {32'h80000000, 32'hC0000000, 1'b0, 1'b0},
        {32'h80000000, 32'h00000001, 1'b0, 1'b0},
        {32'h12345678, 32'h9ABCDEF0, 1'b1, 1'b0},
        {32'h00000000, 32'h7FFFFFFF, 1'b0, 1'b0},
        {32'h00000005, 32'h80000001, 1'b0, 1'b1},
        {32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 count in reset", rd_data, 32'h0);
        chk("R1 req in reset", {31'b0, req_o}, 32'h0);
        por_n = 1'b1;

        // R2: disabled counter holds
        repeat (40) @(negedge clk);
        chk("R2 stopped count", rd_data, 32'h0);

        // R5: first wrap after power-on, no write
        run_en = 1'b1;
        repeat (15) @(negedge clk);
        chk("R5 before wrap", rd_data, 32'h0);
        chk("R5 no req before wrap", {31'b0, req_o}, 32'h0);
        @(negedge clk);
        chk("R5 wrapped", rd_data, 32'hFFFFFFFF);
        chk("R5 req on wrap", {31'b0, req_o}, 32'h1);
        run_en = 1'b0;
        ack_pulse();
        chk("R8 ack clears", {31'b0, req_o}, 32'h0);

        // R3: prescaled stepping
        wr(32'd10);
        chk("R6 no req on msb fall", {31'b0, req_o}, 32'h0);
        run_en = 1'b1;
        repeat (15) @(negedge clk);
        chk("R3 before first step", rd_data, 32'd10);
        @(negedge clk);
        chk("R3 first step", rd_data, 32'd9);
        repeat (16) @(negedge clk);
        chk("R3 second step", rd_data, 32'd8);
        run_en = 1'b0;
        @(negedge clk);

        // R7: write collides with tick
        run_en = 1'b1;
        repeat (15) @(negedge clk);
        wr_en = 1'b1;
        wr_data = 32'd100;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R7 write wins", rd_data, 32'd100);
        repeat (15) @(negedge clk);
        chk("R7 no extra step", rd_data, 32'd100);
        @(negedge clk);
        chk("R7 next step", rd_data, 32'd99);
        run_en = 1'b0;

        // R4: external tick source
        wr(32'd50);
        src_sel = 1'b1;
        run_en = 1'b1;
        repeat (4) @(negedge clk);
        ext_tick = 1'b1;
        repeat (2) @(negedge clk);
        chk("R4 sync latency", rd_data, 32'd50);
        @(negedge clk);
        chk("R4 ext step", rd_data, 32'd49);
        repeat (10) @(negedge clk);
        chk("R4 level ignored", rd_data, 32'd49);
        ext_tick = 1'b0;
        repeat (4) @(negedge clk);
        ext_tick = 1'b1;
        repeat (3) @(negedge clk);
        chk("R4 second edge", rd_data, 32'd48);
        ext_tick = 1'b0;
        run_en = 1'b0;
        src_sel = 1'b0;
        repeat (4) @(negedge clk);

        // R6 / R9: vector table of write pairs
        for (int i = 0; i < 8; i++) begin
            wr(VECS[i][65:34]);
            ack_pulse();
            mask_i = VECS[i][1];
            wr(VECS[i][33:2]);
            chk($sformatf("R6 vec%0d req", i), {31'b0, req_o}, {31'b0, VECS[i][0]});
            chk($sformatf("R6 vec%0d value", i), rd_data, VECS[i][33:2]);
            mask_i = 1'b0;
            ack_pulse();
        end

        // R8: merge
        wr(32'h0);
        wr(32'h80000000);
        wr(32'h1);
        wr(32'h80000002);
        chk("R8 still pending", {31'b0, req_o}, 32'h1);
        ack_pulse();
        chk("R8 one ack clears merged", {31'b0, req_o}, 32'h0);
        repeat (5) @(negedge clk);
        chk("R8 stays clear", {31'b0, req_o}, 32'h0);

        // R9: mask keeps pending, drops new
        wr(32'h0);
        wr(32'h80000000);
        mask_i = 1'b1;
        wr(32'h0);
        wr(32'h80000000);
        chk("R9 pending kept under mask", {31'b0, req_o}, 32'h1);
        ack_pulse();
        chk("R9 masked rise not latched", {31'b0, req_o}, 32'h0);
        mask_i = 1'b0;

        // R11: ack coinciding with a new rise
        wr(32'h0);
        wr(32'h80000000);
        wr(32'h0);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 32'h80000000;
        ack_i = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        ack_i = 1'b0;
        chk("R11 rearm on ack", {31'b0, req_o}, 32'h1);
        ack_pulse();
        chk("R11 later ack clears", {31'b0, req_o}, 32'h0);

        // R10: soft reset
        wr(32'h0);
        wr(32'h80000000);
        wr(32'd1000);
        @(negedge clk);
        run_en = 1'b1;
        sys_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 req cleared", {31'b0, req_o}, 32'h0);
        chk("R10 count kept", rd_data, 32'd1000);
        sys_rst_n = 1'b1;
        repeat (12) @(negedge clk);
        chk("R10 before step", rd_data, 32'd1000);
        @(negedge clk);
        chk("R10 counting continued", rd_data, 32'd999);
        run_en = 1'b0;

        finish_run();
    end
endmodule